// File: doc/BRIEF.md
# 8-bit ALU with Flag Generation

This block is an 8-bit arithmetic and logic unit with its own six-bit status register. Each accepted operation takes two operands and a five-bit operation code, and one clock later presents the registered result together with the updated status bits: carry C, zero Z, negative N, overflow V, sign S and half carry H. The carry used by the carry-chained operations is the C bit the block already holds, so a sequence of operations can run a multi-byte add, subtract, compare or shift without outside help.

Every operation has its own fixed set of status bits that it writes. Bits outside that set keep their value. Compares update the status bits but leave the result register alone. The subtract and compare forms that take the carry keep Z sticky, so that a chain of byte compares gives a correct "all bytes equal" answer. Undefined codes are accepted and leave all state unchanged.

Status bit positions at `flags_o`: bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 S, bit 5 H.

Top module: `alu8_core`

## Requirements
- R1: Add (code 0) writes A+B and add-with-carry (code 1) writes A+B+C. Both set C to the carry out of bit 7, H to the carry out of bit 3 and V to signed overflow.
- R2: Subtract (code 2) gives A-B and subtract-with-carry (code 3) gives A-B-C. Compare (code 4, A-B) and compare-with-carry (code 5, A-B-C) set the same flags but leave the result register unchanged. C is the borrow out of bit 7, H is the borrow from bit 3 and V is signed overflow.
- R3: For codes 3 and 5 the new Z is 1 only if the difference is zero and Z was already 1. For every other status-writing operation, Z is 1 exactly when the result is zero.
- R4: AND (code 6), OR (code 7), XOR (code 8), clear-by-mask (code 9, A AND NOT B) and set-by-mask (code 10, A OR B) clear V and write Z, N and S. C and H are kept.
- R5: Invert (code 11) writes 0xFF-A, sets C to 1 and clears V. H is kept.
- R6: Negate (code 12) writes 0x00-A. C is set when the result is nonzero, V when the result is 0x80, and H to the borrow from bit 3.
- R7: Increment (code 13) writes A+1 and decrement (code 14) writes A-1. V is set only when A+1 gives 0x80 or A-1 gives 0x7F. C and H are kept.
- R8: Shift left (code 15) writes A shifted left with 0 into bit 0. Rotate left (code 16) puts the old C into bit 0. Both set C to old bit 7, H to old bit 3 and V to N XOR C.
- R9: Shift right (code 17) inserts 0 at bit 7, rotate right (code 18) inserts the old C and arithmetic shift right (code 19) keeps bit 7. All three set C to old bit 0 and V to N XOR C, and keep H.
- R10: Nibble swap (code 20) exchanges bits 3..0 with bits 7..4 and changes no status bit.
- R11: After any status-writing operation, N equals result bit 7 and S equals N XOR V. Operand B is ignored by the single-operand codes 11 to 20.
- R12: Reset clears the result, the status bits and `done_o`. Results appear one clock after `op_valid_i`, and `done_o` is high in exactly that cycle. With `op_valid_i` low, nothing changes.
- R13: Codes 21 to 31 leave the result and all status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid_i | input | 1 | Accept an operation this cycle |
| op_code_i | input | 5 | Operation code (see requirements) |
| opa_i | input | 8 | First operand A |
| opb_i | input | 8 | Second operand B or mask |
| result_o | output | 8 | Registered result |
| flags_o | output | 6 | Status bits {H,S,V,N,Z,C} |
| done_o | output | 1 | Result and status updated in this cycle |

## Verification
Every cycle, the embedded properties check these rules: S matches N XOR V, idle cycles change nothing, increment and decrement keep C and H, swap leaves the flags alone, compares keep the result, invert sets C, the logic group clears V, and a cleared Z stays cleared through the carry-chained subtracts. The arithmetic values themselves can only be shown by the bench's scenarios. These are the sums, borrows, half carries, overflow and the shift and rotate bit patterns. The bench sweeps every A value under each code, with a set of boundary B values. Before each operation it applies a preceding operation that sets up one of four carry/zero states.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OPC_W  = 5;
  localparam int FLAG_W = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBC = 5'd3,
    OP_CMP  = 5'd4,
    OP_CMPC = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_MCLR = 5'd9,
    OP_MSET = 5'd10,
    OP_INV  = 5'd11,
    OP_NEG  = 5'd12,
    OP_INC  = 5'd13,
    OP_DEC  = 5'd14,
    OP_SHL  = 5'd15,
    OP_RLC  = 5'd16,
    OP_SHR  = 5'd17,
    OP_RRC  = 5'd18,
    OP_SAR  = 5'd19,
    OP_NSWP = 5'd20
  } alu_op_e;

  // status bits written by each operation
  function automatic logic [FLAG_W-1:0] flag_mask(input logic [OPC_W-1:0] code);
    logic [FLAG_W-1:0] m;
    case (code)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP, OP_CMPC,
      OP_NEG, OP_SHL, OP_RLC:                  m = 6'b111111;
      OP_AND, OP_OR, OP_XOR, OP_MCLR, OP_MSET,
      OP_INC, OP_DEC:                          m = 6'b011110;
      OP_INV, OP_SHR, OP_RRC, OP_SAR:          m = 6'b011111;
      default:                                 m = 6'b000000;
    endcase
    return m;
  endfunction

  function automatic logic writes_result(input logic [OPC_W-1:0] code);
    return (code <= OP_NSWP) && (code != OP_CMP) && (code != OP_CMPC);
  endfunction

  function automatic logic on_adder(input logic [OPC_W-1:0] code);
    case (code)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP, OP_CMPC,
      OP_NEG, OP_INC, OP_DEC, OP_SHL, OP_RLC: return 1'b1;
      default:                                return 1'b0;
    endcase
  endfunction

  function automatic logic is_subtract(input logic [OPC_W-1:0] code);
    case (code)
      OP_SUB, OP_SUBC, OP_CMP, OP_CMPC, OP_NEG, OP_DEC: return 1'b1;
      default:                                          return 1'b0;
    endcase
  endfunction

  function automatic logic takes_carry(input logic [OPC_W-1:0] code);
    case (code)
      OP_ADDC, OP_SUBC, OP_CMPC, OP_RLC: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  function automatic logic zero_chained(input logic [OPC_W-1:0] code);
    return (code == OP_SUBC) || (code == OP_CMPC);
  endfunction

  function automatic logic shifts_right(input logic [OPC_W-1:0] code);
    return (code == OP_SHR) || (code == OP_RRC) || (code == OP_SAR);
  endfunction

endpackage

// File: rtl/alu8_rst_sync.sv
module alu8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         half_o,
  output logic         ovf_o
);
  localparam int MSB  = W - 1;
  localparam int HALF = W / 2;

  logic [W-1:0]  b_eff;
  logic          c_eff;
  logic [W:0]    full;
  logic [HALF:0] low;

  always_comb begin
    // subtraction as a + ~b + ~borrow; borrows are inverted carries
    b_eff  = sub_i ? ~b_i : b_i;
    c_eff  = sub_i ? ~cin_i : cin_i;
    full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    low    = {1'b0, a_i[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, c_eff};
    sum_o  = full[W-1:0];
    cout_o = sub_i ? ~full[W] : full[W];
    half_o = sub_i ? ~low[HALF] : low[HALF];
    ovf_o  = (a_i[MSB] == b_eff[MSB]) && (full[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OPC_W-1:0] code_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             cin_i,
  output logic [W-1:0]     res_o,
  output logic             cout_o
);
  localparam int MSB  = W - 1;
  localparam int HALF = W / 2;

  logic [W-1:0] swapped;

  for (genvar i = 0; i < W; i++) begin : g_swap
    assign swapped[i] = a_i[(i + HALF) % W];
  end

  always_comb begin
    res_o  = a_i;
    cout_o = cin_i;
    case (code_i)
      OP_AND:          res_o = a_i & b_i;
      OP_OR, OP_MSET:  res_o = a_i | b_i;
      OP_XOR:          res_o = a_i ^ b_i;
      OP_MCLR:         res_o = a_i & ~b_i;
      OP_INV: begin
        res_o  = ~a_i;
        cout_o = 1'b1;
      end
      OP_SHR: begin
        res_o  = {1'b0, a_i[MSB:1]};
        cout_o = a_i[0];
      end
      OP_RRC: begin
        res_o  = {cin_i, a_i[MSB:1]};
        cout_o = a_i[0];
      end
      OP_SAR: begin
        res_o  = {a_i[MSB], a_i[MSB:1]};
        cout_o = a_i[0];
      end
      OP_NSWP:         res_o = swapped;
      default: begin
        res_o  = a_i;
        cout_o = cin_i;
      end
    endcase
  end
endmodule

// File: rtl/alu8_state.sv
module alu8_state
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              wr_res_i,
  input  logic [W-1:0]      res_i,
  input  logic [FLAG_W-1:0] fmask_i,
  input  logic [FLAG_W-1:0] fcand_i,
  output logic [W-1:0]      res_q_o,
  output logic [FLAG_W-1:0] flags_q_o,
  output logic              done_q_o
);
  logic [W-1:0]      res_q,   res_d;
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic              done_q,  done_d;

  always_comb begin
    res_d   = wr_res_i ? res_i : res_q;
    flags_d = (flags_q & ~fmask_i) | (fcand_i & fmask_i);
    done_d  = en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (en_i) begin
        res_q   <= res_d;
        flags_q <= flags_d;
      end
    end
  end

  assign res_q_o   = res_q;
  assign flags_q_o = flags_q;
  assign done_q_o  = done_q;

  // R12: idle cycles leave the result and status untouched
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(res_q) && $stable(flags_q)));

  // R11: the sign bit always agrees with N xor V
  p_sign_rule_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[FS] == (flags_q[FN] ^ flags_q[FV]));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  input  logic [OPC_W-1:0]  op_code_i,
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  output logic [W-1:0]      result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              done_o
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic              rst_sync_n;
  logic [FLAG_W-1:0] flags_q;
  logic              use_add, do_sub, chain_c, sticky_z, right_sh;
  logic [W-1:0]      add_a, add_b, add_sum, bit_res, res_sel;
  logic              add_c, add_h, add_v, bit_c, cin;
  logic              n_new, c_new, v_new, z_new, res_zero;
  logic [FLAG_W-1:0] fcand, fmask;

  alu8_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // operand steering for the shared adder
  always_comb begin
    use_add  = on_adder(op_code_i);
    do_sub   = is_subtract(op_code_i);
    chain_c  = takes_carry(op_code_i);
    sticky_z = zero_chained(op_code_i);
    right_sh = shifts_right(op_code_i);
    cin      = chain_c ? flags_q[FC] : 1'b0;
    add_a    = (op_code_i == OP_NEG) ? '0 : opa_i;
    case (op_code_i)
      OP_NEG, OP_SHL, OP_RLC: add_b = opa_i;
      OP_INC, OP_DEC:         add_b = ONE;
      default:                add_b = opb_i;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a_i    (add_a),
    .b_i    (add_b),
    .cin_i  (cin),
    .sub_i  (do_sub),
    .sum_o  (add_sum),
    .cout_o (add_c),
    .half_o (add_h),
    .ovf_o  (add_v)
  );

  alu8_bitops #(.W(W)) u_bitops (
    .code_i (op_code_i),
    .a_i    (opa_i),
    .b_i    (opb_i),
    .cin_i  (flags_q[FC]),
    .res_o  (bit_res),
    .cout_o (bit_c)
  );

  // candidate status bits; the mask decides which of them land
  always_comb begin
    res_sel  = use_add ? add_sum : bit_res;
    res_zero = (res_sel == '0);
    n_new    = res_sel[MSB];
    c_new    = use_add ? add_c : bit_c;
    if (use_add)       v_new = add_v;
    else if (right_sh) v_new = n_new ^ c_new;
    else               v_new = 1'b0;
    z_new    = sticky_z ? (res_zero & flags_q[FZ]) : res_zero;
    fcand        = '0;
    fcand[FC]    = c_new;
    fcand[FZ]    = z_new;
    fcand[FN]    = n_new;
    fcand[FV]    = v_new;
    fcand[FS]    = n_new ^ v_new;
    fcand[FH]    = add_h;
    fmask        = flag_mask(op_code_i);
  end

  alu8_state #(.W(W)) u_state (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en_i      (op_valid_i),
    .wr_res_i  (writes_result(op_code_i)),
    .res_i     (res_sel),
    .fmask_i   (fmask),
    .fcand_i   (fcand),
    .res_q_o   (result_o),
    .flags_q_o (flags_q),
    .done_q_o  (done_o)
  );

  assign flags_o = flags_q;

  // R12: done marks exactly the cycle after an accepted operation
  p_done_after_valid_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid_i |=> done_o);
  p_no_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid_i |=> !done_o);

  // R7: increment and decrement keep carry and half carry
  p_incdec_keep_ch_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && (op_code_i == OP_INC || op_code_i == OP_DEC))
      |=> (flags_o[FC] == $past(flags_o[FC])) && (flags_o[FH] == $past(flags_o[FH])));

  // R10: nibble swap changes no status bit
  p_swap_flags_stable_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && op_code_i == OP_NSWP) |=> $stable(flags_o));

  // R2: compares keep the result register
  p_cmp_keeps_result_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && (op_code_i == OP_CMP || op_code_i == OP_CMPC)) |=> $stable(result_o));

  // R3: a cleared Z stays cleared through carry-chained subtracts
  p_z_sticky_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && (op_code_i == OP_SUBC || op_code_i == OP_CMPC) && !flags_o[FZ])
      |=> !flags_o[FZ]);

  // R5: invert always sets carry
  p_inv_sets_carry_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && op_code_i == OP_INV) |=> flags_o[FC]);

  // R4: logic group clears overflow
  p_logic_v_clear_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && op_code_i >= OP_AND && op_code_i <= OP_MSET) |=> !flags_o[FV]);
endmodule

// File: tb/test_alu8_core.sv
`timescale 1ns/1ps
module test_alu8_core;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [4:0] op_code;
  logic [7:0] opa, opb;
  logic [7:0] result;
  logic [5:0] flags;
  logic       done;

  int n_chk = 0;
  int n_bad = 0;
  int exp_res = 0;
  int exp_fl = 0;
  int cycles = 0;
  bit finished = 1'b0;

  alu8_core #(.W(8)) i_alu8_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid_i (op_valid),
    .op_code_i  (op_code),
    .opa_i      (opa),
    .opb_i      (opb),
    .result_o   (result),
    .flags_o    (flags),
    .done_o     (done)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      n_bad++;
      $display("FAIL R12 watchdog: actual %0d cycles expected fewer than 190000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic string req_tag(input int code);
    case (code)
      0, 1:       return "R1";
      2, 4:       return "R2";
      3, 5:       return "R2/R3";
      6, 7, 8, 9, 10: return "R4";
      11:         return "R5";
      12:         return "R6";
      13, 14:     return "R7";
      15, 16:     return "R8";
      17, 18, 19: return "R9";
      20:         return "R10";
      default:    return "R13";
    endcase
  endfunction

  // expected behaviour computed from the requirements
  task automatic model(input int code, input int a, input int b);
    int fc, fz, fn, fv, fs, fh, val, x, y, ci, t, st;
    bit upd, wr, sticky;
    fc = exp_fl & 1;        fz = (exp_fl >> 1) & 1;
    fn = (exp_fl >> 2) & 1; fv = (exp_fl >> 3) & 1;
    fs = (exp_fl >> 4) & 1; fh = (exp_fl >> 5) & 1;
    upd = 1'b1; sticky = 1'b0; val = exp_res;
    wr = !(code == 4 || code == 5 || code > 20);
    case (code)
      0, 1, 13, 15, 16: begin
        x  = a;
        y  = (code == 13) ? 1 : ((code >= 15) ? a : b);
        ci = (code == 1 || code == 16) ? fc : 0;
        t  = x + y + ci;
        val = t & 255;
        st = sgn(x) + sgn(y) + ci;
        fv = (st > 127 || st < -128) ? 1 : 0;
        if (code != 13) begin
          fc = (t > 255) ? 1 : 0;
          fh = (((x & 15) + (y & 15) + ci) > 15) ? 1 : 0;
        end
      end
      2, 3, 4, 5, 12, 14: begin
        x  = (code == 12) ? 0 : a;
        y  = (code == 12) ? a : ((code == 14) ? 1 : b);
        ci = (code == 3 || code == 5) ? fc : 0;
        t  = x - y - ci;
        val = t & 255;
        st = sgn(x) - sgn(y) - ci;
        fv = (st > 127 || st < -128) ? 1 : 0;
        if (code != 14) begin
          fc = (t < 0) ? 1 : 0;
          fh = (((x & 15) - (y & 15) - ci) < 0) ? 1 : 0;
        end
        sticky = (code == 3 || code == 5);
      end
      6:     begin val = a & b;         fv = 0; end
      7, 10: begin val = a | b;         fv = 0; end
      8:     begin val = a ^ b;         fv = 0; end
      9:     begin val = a & (255 - b); fv = 0; end
      11:    begin val = 255 - a; fc = 1; fv = 0; end
      17, 18, 19: begin
        if (code == 17)      val = a >> 1;
        else if (code == 18) val = (fc << 7) | (a >> 1);
        else                 val = (a & 128) | (a >> 1);
        fc = a & 1;
        fv = ((val >> 7) & 1) ^ fc;
      end
      20:    begin val = ((a & 15) << 4) | (a >> 4); upd = 1'b0; end
      default: upd = 1'b0;
    endcase
    if (wr) exp_res = val;
    if (upd) begin
      fn = (val >> 7) & 1;
      fs = fn ^ fv;
      fz = sticky ? (((val == 0) && (fz == 1)) ? 1 : 0) : ((val == 0) ? 1 : 0);
      exp_fl = fc | (fz << 1) | (fn << 2) | (fv << 3) | (fs << 4) | (fh << 5);
    end
  endtask

  task automatic run_op(input int code, input int a, input int b);
    op_code  = code[4:0];
    opa      = a[7:0];
    opb      = b[7:0];
    op_valid = 1'b1;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    model(code, a, b);
    check(req_tag(code), "result", int'(result), exp_res);
    check({req_tag(code), "/R11"}, "flags", int'(flags), exp_fl);
    check("R12", "done", int'(done), 1);
  endtask

  // four distinct carry/zero starting states
  task automatic pre(input int p);
    case (p)
      0:       run_op(0, 0, 0);     // C0 Z1
      1:       run_op(2, 0, 1);     // C1 Z0
      2:       run_op(0, 255, 1);   // C1 Z1
      default: run_op(0, 1, 1);     // C0 Z0
    endcase
  endtask

  task automatic idle(input int code, input int a, input int b);
    op_code  = code[4:0];
    opa      = a[7:0];
    opb      = b[7:0];
    op_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R12", "idle result", int'(result), exp_res);
    check("R12", "idle flags", int'(flags), exp_fl);
    check("R12", "idle done", int'(done), 0);
  endtask

  int blist[8] = '{0, 1, 15, 16, 127, 128, 255, 90};

  initial begin
    rst_n    = 1'b0;
    op_valid = 1'b0;
    op_code  = '0;
    opa      = '0;
    opb      = '0;
    repeat (4) @(posedge clk);
    #1;
    check("R12", "reset result", int'(result), 0);
    check("R12", "reset flags", int'(flags), 0);
    check("R12", "reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    exp_res = 0;
    exp_fl  = 0;

    for (int op = 0; op < 21; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 8; bi++) begin
          pre((a + bi) % 4);
          run_op(op, a, blist[bi]);
        end
        if (a % 16 == 0) idle(op, 255 - a, a);
      end
    end

    // R13: undefined codes change nothing
    for (int code = 21; code < 32; code++) begin
      for (int k = 0; k < 16; k++) begin
        pre(k % 4);
        run_op(code, k * 17, 255 - k * 16);
      end
    end

    idle(0, 200, 100);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule